// File: doc/BRIEF.md
# Glitch-Filtered Serial Configuration Loader

This block loads a 6-bit configuration word through pins that also carry other functions. Four phase-drive inputs act as the strobe. When all four of them sit low together, the block is in programming mode. If that all-low state lasts long enough, the block makes exactly one internal shift pulse. The bit shifted in on that pulse is the exclusive-OR of two data inputs.

A short all-low interval is treated as a glitch and ignored. A long interval still gives only one bit. Before the next bit can be loaded, at least one phase input must rise and the group must then fall low again. While programming mode is active, the block raises a flag that the surrounding logic uses to turn every power output off.

All inputs pass through synchronizers, and the minimum low time is a parameter counted in system clock cycles.

Top module: `cfg_loader`

## Requirements
- R1: `prog_active` is 1 from the third rising clock edge after all four `ph_in` bits are sampled low, and returns to 0 by the third edge after any `ph_in` bit is sampled high.
- R2: A shift occurs only when `ph_in` has been 4'b0000 for at least `MIN_LOW_CYC` consecutive clock samples. With the default of 40, an interval of 39 samples leaves `cfg_word` unchanged, while an interval of exactly 40 samples shifts once.
- R3: The bit shifted in equals `dat_a` XOR `dat_b`, taken while the qualifying all-low interval is in progress.
- R4: One all-low interval produces at most one shift, however long it lasts. A further shift needs at least one `ph_in` bit to be sampled high, even for a single cycle, followed by a new qualifying all-low interval.
- R5: Each shift moves the new bit into `cfg_word[0]` and moves every older bit one position toward `cfg_word[5]`. The old `cfg_word[5]` is discarded. After six shifts, the first bit loaded sits in bit 5.
- R6: A synchronous active-high `rst` clears `cfg_word` to 6'b000000 and `prog_active` to 0.
- R7: `cfg_word` holds its value in every cycle without a shift. This includes long intervals in which one or more `ph_in` bits stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_in | input | PH_W (4) | Phase-drive inputs; all low selects programming mode and strobes the shift |
| dat_a | input | 1 | First serial data input |
| dat_b | input | 1 | Second serial data input |
| cfg_word | output | CFG_W (6) | Configuration register |
| prog_active | output | 1 | High while programming mode is active; forces the power outputs off |

## Verification
Low intervals one sample short of the threshold and exactly at the threshold separate a correct minimum-time qualifier from an off-by-one qualifier. All four data combinations are applied, which separates the XOR from OR, AND or a single input. A low interval three times the threshold, followed by a one-cycle high blip, separates correct re-arming from repeated firing and from re-arming that is missed. A run of seven known bits exposes any error in the shift direction and shows that the oldest bit drops out of bit 5.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;
  localparam int DEF_PH_W    = 4;
  localparam int DEF_CFG_W   = 6;
  localparam int DEF_MIN_LOW = 40;  // 200 ns at 200 MHz
  localparam int DEF_SYNC    = 2;
endpackage

// File: rtl/cfgload_sync.sv
module cfgload_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfgload_qual.sv
module cfgload_qual #(
  parameter int MIN_LOW_CYC = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic all_low,
  output logic shift_pulse
);
  localparam int CW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_LOW_CYC - 1);

  logic [CW-1:0] low_cnt;
  logic          armed;

  assign shift_pulse = all_low && armed && (low_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      armed   <= 1'b1;
    end else if (!all_low) begin
      low_cnt <= '0;
      armed   <= 1'b1;
    end else if (armed) begin
      if (low_cnt == LAST) begin
        low_cnt <= '0;
        armed   <= 1'b0;
      end else begin
        low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  // R4: a pulse never lasts more than one cycle
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    shift_pulse |=> !shift_pulse);
  // R4: after a pulse, no new pulse occurs while the group stays low
  assert_no_refire_R4: assert property (@(posedge clk) disable iff (rst)
    (shift_pulse ##1 all_low) |-> !shift_pulse);
endmodule

// File: rtl/cfgload_shreg.sv
module cfgload_shreg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] cfg
);
  always_ff @(posedge clk) begin
    if (rst)           cfg <= '0;
    else if (shift_en) cfg <= {cfg[W-2:0], bit_in};
  end

  // R6: reset clears the word
  assert_reset_clear_R6: assert property (@(posedge clk)
    rst |=> (cfg == '0));
  // R7: no shift, no change
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(cfg));
  // R5: new bit enters bit 0, older bits move up
  assert_shift_dir_R5: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (cfg[W-1:1] == $past(cfg[W-2:0])) && (cfg[0] == $past(bit_in)));
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfgload_pkg::*;
#(
  parameter int PH_W        = DEF_PH_W,
  parameter int CFG_W       = DEF_CFG_W,
  parameter int MIN_LOW_CYC = DEF_MIN_LOW,
  parameter int SYNC_STAGES = DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  ph_in,
  input  logic             dat_a,
  input  logic             dat_b,
  output logic [CFG_W-1:0] cfg_word,
  output logic             prog_active
);
  logic [PH_W-1:0] ph_s;
  logic [1:0]      dat_s;
  logic            all_low;
  logic            shift_pulse;
  logic            ser_bit;

  // phases reset high so that reset does not look like programming mode
  cfgload_sync #(.W(PH_W), .STAGES(SYNC_STAGES), .RST_VAL({PH_W{1'b1}})) u_ph_sync (
    .clk(clk), .rst(rst), .d(ph_in), .q(ph_s));

  cfgload_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_dat_sync (
    .clk(clk), .rst(rst), .d({dat_b, dat_a}), .q(dat_s));

  assign all_low = (ph_s == '0);
  assign ser_bit = dat_s[0] ^ dat_s[1];

  always_ff @(posedge clk) begin
    if (rst) prog_active <= 1'b0;
    else     prog_active <= all_low;
  end

  cfgload_qual #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_qual (
    .clk(clk), .rst(rst), .all_low(all_low), .shift_pulse(shift_pulse));

  cfgload_shreg #(.W(CFG_W)) u_shreg (
    .clk(clk), .rst(rst), .shift_en(shift_pulse), .bit_in(ser_bit), .cfg(cfg_word));

  initial begin
    assert_min_low_R2: assert (MIN_LOW_CYC >= 2);
  end

  // R1: any synchronized phase high drops the flag next cycle
  assert_flag_off_R1: assert property (@(posedge clk) disable iff (rst)
    (ph_s != '0) |=> !prog_active);
  // R2: a shift only happens inside an all-low interval already flagged
  assert_pulse_in_prog_R2: assert property (@(posedge clk) disable iff (rst)
    shift_pulse |-> (prog_active && all_low));
  // R7: word never changes while the flag is down
  assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!prog_active && !all_low) |=> $stable(cfg_word));
endmodule

// File: tb/cfg_loader_test.sv
`timescale 1ns/1ps
module cfg_loader_test;
  localparam int MIN = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] ph_in = 4'b1111;
  logic       dat_a = 1'b0;
  logic       dat_b = 1'b0;
  logic [5:0] cfg_word;
  logic       prog_active;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  logic [5:0] exp_cfg = 6'd0;

  always #2.5 clk = ~clk;

  cfg_loader #(.MIN_LOW_CYC(MIN)) uut (
    .clk(clk), .rst(rst), .ph_in(ph_in), .dat_a(dat_a), .dat_b(dat_b),
    .cfg_word(cfg_word), .prog_active(prog_active));

  task automatic chk(input string req, input logic [5:0] got, input logic [5:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit: low for len samples, then high for 4 samples
  task automatic send_bit(input logic a, input logic b, input int len, input bit counts);
    dat_a = a; dat_b = b;
    ph_in = 4'b0000;
    cyc(len);
    ph_in = 4'b1111;
    cyc(4);
    if (counts) exp_cfg = {exp_cfg[4:0], a ^ b};
  endtask

  task automatic t_reset;
    rst = 1'b1; cyc(3); rst = 1'b0; cyc(3);
    exp_cfg = 6'd0;
    chk("R6 reset word", cfg_word, 6'd0);
    chk("R6 reset flag", {5'd0, prog_active}, 6'd0);
  endtask

  task automatic t_flag;
    ph_in = 4'b0000; cyc(5);
    chk("R1 flag on", {5'd0, prog_active}, 6'd1);
    ph_in = 4'b1000; cyc(5);
    chk("R1 flag off", {5'd0, prog_active}, 6'd0);
    ph_in = 4'b0100; cyc(3 * MIN);
    chk("R7 one phase high holds", cfg_word, exp_cfg);
    chk("R1 flag off one high", {5'd0, prog_active}, 6'd0);
    ph_in = 4'b1111; cyc(4);
    chk("R2 flag-only interval too short", cfg_word, exp_cfg);
  endtask

  task automatic t_threshold;
    send_bit(1'b1, 1'b0, MIN - 1, 1'b0);
    chk("R2 short interval ignored", cfg_word, exp_cfg);
    send_bit(1'b1, 1'b0, MIN, 1'b1);
    chk("R2 exact interval shifts", cfg_word, exp_cfg);
  endtask

  task automatic t_xor;
    send_bit(1'b0, 1'b1, MIN + 5, 1'b1);
    chk("R3 xor 0,1", cfg_word, exp_cfg);
    send_bit(1'b1, 1'b1, MIN + 5, 1'b1);
    chk("R3 xor 1,1", cfg_word, exp_cfg);
    send_bit(1'b0, 1'b0, MIN + 5, 1'b1);
    chk("R3 xor 0,0", cfg_word, exp_cfg);
    send_bit(1'b1, 1'b0, MIN + 5, 1'b1);
    chk("R3 xor 1,0", cfg_word, exp_cfg);
  endtask

  task automatic t_order;
    logic [6:0] seq = 7'b1011001;  // bit 6 sent first
    rst = 1'b1; cyc(2); rst = 1'b0; cyc(2);
    exp_cfg = 6'd0;
    for (int i = 6; i >= 1; i--) send_bit(seq[i], 1'b0, MIN + 2, 1'b1);
    chk("R5 six bits, first in bit 5", cfg_word, 6'b101100);
    send_bit(seq[0], 1'b0, MIN + 2, 1'b1);
    chk("R5 seventh bit drops oldest", cfg_word, 6'b011001);
  endtask

  task automatic t_rearm;
    send_bit(1'b1, 1'b0, 3 * MIN, 1'b1);
    chk("R4 long interval one shift", cfg_word, exp_cfg);
    dat_a = 1'b1; dat_b = 1'b0;
    ph_in = 4'b0000; cyc(MIN + 2);
    ph_in = 4'b0010; cyc(1);
    ph_in = 4'b0000; cyc(MIN + 2);
    ph_in = 4'b1111; cyc(4);
    exp_cfg = {exp_cfg[3:0], 2'b11};
    chk("R4 one-cycle blip re-arms", cfg_word, exp_cfg);
  endtask

  task automatic t_midreset;
    rst = 1'b1; cyc(2); rst = 1'b0; cyc(2);
    exp_cfg = 6'd0;
    chk("R6 reset after load", cfg_word, 6'd0);
  endtask

  initial begin
    t_reset();
    t_flag();
    t_threshold();
    t_xor();
    t_order();
    t_rearm();
    t_midreset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule